// File: doc/BRIEF.md
# Dual-Channel DAC Sample Unpacker

This block sits between an output DMA word stream and two DAC sample paths. On every sample-rate strobe it produces one signed 20-bit sample for each of two channels and raises a one-cycle valid strobe. The samples are drawn from a single stream of 32-bit words.

A small control byte gives each channel an enable bit and a resolution bit. At 16-bit resolution one stream word carries two samples. At 20-bit resolution one word carries one sample.

Each strobe is served in two consecutive cycles. The first cycle is channel 0's slot and the second is channel 1's slot. In its own slot a channel asks the stream for a word when it needs one. If the word is missing, the channel repeats its previous sample and a sticky underrun flag is raised. The sample-rate strobe must come at least three cycles apart.

Top module: `dac_unpack`

## Requirements
- R1: After reset, both samples are zero. The underrun, sample_valid and word_ready outputs are low. Only reset clears underrun.
- R2: Control bit 0 enables channel 0 and bit 1 puts it in 20-bit mode (0 means 16-bit mode). Bit 4 enables channel 1 and bit 5 puts it in 20-bit mode. Bits 2, 3, 6 and 7 have no effect.
- R3: A tick seen while idle starts a service. The cycle after the tick is channel 0's slot and the next cycle is channel 1's slot. sample_valid is high for exactly one cycle, the cycle after channel 1's slot, and both samples update together at that point. A tick that arrives during a service is ignored.
- R4: In 16-bit mode a word's bits 15:0 are played first. Its bits 31:16 are played at the next tick, and no word is requested for that second sample. Each 16-bit sample appears as its value followed by four zero LSBs.
- R5: In 20-bit mode each tick consumes one word. Word bits 19:0 become the sample, and bits 31:20 are ignored.
- R6: A disabled channel outputs zero and never asserts word_ready. It also discards any held upper halfword.
- R7: When a channel needs a word in its slot and word_valid is low, it repeats its last sample and underrun is set and stays set.
- R8: When both channels need a word in the same service, channel 0's word is taken from the stream before channel 1's word.
- R9: A channel in 20-bit mode always requests a word, even if a 16-bit upper halfword is still held. The held halfword is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl | input | 8 | Per-channel enable and resolution bits |
| tick | input | 1 | Sample-rate strobe |
| word_valid | input | 1 | Stream word present |
| word_data | input | 32 | Stream word |
| word_ready | output | 1 | Word accepted this cycle when word_valid is high |
| ch0_sample | output | 20 | Channel 0 signed sample |
| ch1_sample | output | 20 | Channel 1 signed sample |
| sample_valid | output | 1 | One-cycle pulse when new samples are presented |
| underrun | output | 1 | Sticky: a needed word was missing |

## Verification
The hardest state to reach from the ports is a channel holding an upper halfword when its mode or enable bit changes, or when an underrun arrives just as the next pair is due. That state exists only between two ticks and leaves no direct trace at the outputs. The vector table walks one continuous sequence without resets between entries, so each entry inherits the held halves left by the one before. Specific entries then switch a channel to 20-bit mode or disable it while a half is held. They also withhold the channel 1 word in the slot where a fresh pair is needed.

// File: rtl/dac_unpack.sv
module dac_unpack #(
  parameter int WORD_W   = 32,
  parameter int HALF_W   = 16,
  parameter int SAMPLE_W = 20
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [7:0]                 ctrl,
  input  logic                       tick,
  input  logic                       word_valid,
  input  logic [WORD_W-1:0]          word_data,
  output logic                       word_ready,
  output logic signed [SAMPLE_W-1:0] ch0_sample,
  output logic signed [SAMPLE_W-1:0] ch1_sample,
  output logic                       sample_valid,
  output logic                       underrun
);
  localparam int PAD = SAMPLE_W - HALF_W;

  typedef enum logic [1:0] {IDLE, SLOT0, SLOT1} st_t;
  st_t st;

  logic [SAMPLE_W-1:0] cur   [2];
  logic [HALF_W-1:0]   upper [2];
  logic [1:0]          half;
  logic                sel, en_s, wide_s, need, nxt_h;
  logic [SAMPLE_W-1:0] nxt_s;
  logic                unused_ctrl;

  assign sel         = (st == SLOT1);
  assign en_s        = ctrl[{sel, 2'b00}];
  assign wide_s      = ctrl[{sel, 2'b01}];
  assign need        = (st != IDLE) && en_s && (wide_s || !half[sel]);
  assign word_ready  = need;
  assign unused_ctrl = ^{ctrl[7:6], ctrl[3:2]};

  always_comb begin
    nxt_s = cur[sel];
    nxt_h = 1'b0;
    if (!en_s)
      nxt_s = '0;
    else if (!need)
      nxt_s = {upper[sel], {PAD{1'b0}}};
    else if (word_valid) begin
      if (wide_s)
        nxt_s = word_data[SAMPLE_W-1:0];
      else begin
        nxt_s = {word_data[HALF_W-1:0], {PAD{1'b0}}};
        nxt_h = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st           <= IDLE;
      cur[0]       <= '0;
      cur[1]       <= '0;
      upper[0]     <= '0;
      upper[1]     <= '0;
      half         <= '0;
      ch0_sample   <= '0;
      ch1_sample   <= '0;
      sample_valid <= 1'b0;
      underrun     <= 1'b0;
    end else begin
      sample_valid <= (st == SLOT1);
      case (st)
        IDLE:    if (tick) st <= SLOT0;
        SLOT0:   st <= SLOT1;
        default: st <= IDLE;
      endcase
      if (st != IDLE) begin
        cur[sel]  <= nxt_s;
        half[sel] <= nxt_h;
        if (need && word_valid && !wide_s)
          upper[sel] <= word_data[WORD_W-1:WORD_W-HALF_W];
        if (need && !word_valid)
          underrun <= 1'b1;
      end
      if (st == SLOT1) begin
        ch0_sample <= cur[0];
        ch1_sample <= nxt_s;
      end
    end
  end

  AST_UNDERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |=> underrun);  // R7
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid |=> !sample_valid);  // R3
  AST_OFF_ZERO0: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid && !$past(ctrl[0], 2) |-> ch0_sample == '0);  // R6
  AST_OFF_ZERO1: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid && !$past(ctrl[4]) |-> ch1_sample == '0);  // R6
  AST_NARROW_PAD: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid && $past(ctrl[0] && !ctrl[1], 2) |-> ch0_sample[PAD-1:0] == '0);  // R4
  AST_WIDE_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid && $past(ctrl[0] && ctrl[1] && word_ready && word_valid, 2)
    |-> ch0_sample == $past(word_data[SAMPLE_W-1:0], 2));  // R5
endmodule

// File: tb/test_dac_unpack.sv
`timescale 1ns/1ps
module test_dac_unpack;
  typedef struct packed {
    logic [7:0]  c;
    logic        v0;
    logic [31:0] w0;
    logic        v1;
    logic [31:0] w1;
    logic [19:0] e0;
    logic [19:0] e1;
    logic        t0;
    logic        t1;
    logic        u;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{8'h00, 1'b1, 32'hAAAA_BBBB, 1'b1, 32'hCCCC_DDDD, 20'h00000, 20'h00000, 1'b0, 1'b0, 1'b0},
    '{8'h11, 1'b1, 32'h1111_2222, 1'b1, 32'h3333_4444, 20'h22220, 20'h44440, 1'b1, 1'b1, 1'b0},
    '{8'h11, 1'b1, 32'hDEAD_BEEF, 1'b1, 32'hDEAD_BEEF, 20'h11110, 20'h33330, 1'b0, 1'b0, 1'b0},
    '{8'h33, 1'b1, 32'hFFF8_0001, 1'b1, 32'hABC7_FFFF, 20'h80001, 20'h7FFFF, 1'b1, 1'b1, 1'b0},
    '{8'h13, 1'b1, 32'h0001_2345, 1'b1, 32'h5678_9ABC, 20'h12345, 20'h9ABC0, 1'b1, 1'b1, 1'b0},
    '{8'h31, 1'b1, 32'h0F0F_A5A5, 1'b1, 32'h000C_0DE0, 20'hA5A50, 20'hC0DE0, 1'b1, 1'b1, 1'b0},
    '{8'h33, 1'b1, 32'h0004_4444, 1'b1, 32'h0002_2222, 20'h44444, 20'h22222, 1'b1, 1'b1, 1'b0},
    '{8'h11, 1'b1, 32'h7777_6666, 1'b1, 32'h9999_8888, 20'h66660, 20'h88880, 1'b1, 1'b1, 1'b0},
    '{8'h10, 1'b1, 32'h5555_5555, 1'b1, 32'h5555_5555, 20'h00000, 20'h99990, 1'b0, 1'b0, 1'b0},
    '{8'h11, 1'b1, 32'h0000_1357, 1'b0, 32'h0000_0000, 20'h13570, 20'h99990, 1'b1, 1'b0, 1'b1},
    '{8'h11, 1'b1, 32'h1212_1212, 1'b1, 32'h2468_ACE0, 20'h00000, 20'hACE00, 1'b0, 1'b1, 1'b1},
    '{8'hCD, 1'b1, 32'h5555_AAAA, 1'b1, 32'h1234_5678, 20'hAAAA0, 20'h00000, 1'b1, 1'b0, 1'b1}
  };

  logic        clk = 1'b0, rst_n = 1'b0, tick = 1'b0, word_valid = 1'b0;
  logic [7:0]  ctrl = 8'h00;
  logic [31:0] word_data = '0;
  logic        word_ready, sample_valid, underrun;
  logic signed [19:0] ch0_sample, ch1_sample;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  dac_unpack i_dac_unpack (
    .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .tick(tick),
    .word_valid(word_valid), .word_data(word_data), .word_ready(word_ready),
    .ch0_sample(ch0_sample), .ch1_sample(ch1_sample),
    .sample_valid(sample_valid), .underrun(underrun)
  );

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic string tag(input int i);
    case (i)
      0:       return "R6 vec0";
      1:       return "R4 R8 vec1";
      2:       return "R4 vec2";
      3, 4:    return "R5 vec3-4";
      5:       return "R4 R5 vec5";
      6:       return "R9 vec6";
      7:       return "R4 R8 vec7";
      8:       return "R6 vec8";
      9:       return "R7 vec9";
      10:      return "R7 vec10";
      default: return "R2 vec11";
    endcase
  endfunction

  task automatic apply(input vec_t v, input int i);
    logic tk0, tk1;
    @(negedge clk); ctrl = v.c; tick = 1'b1; word_valid = 1'b0;
    @(negedge clk); tick = 1'b0; word_valid = v.v0; word_data = v.w0;
    #1 tk0 = word_ready && word_valid;
    chk(sample_valid == 1'b0, "R3 early valid", {31'b0, sample_valid}, 32'd0);
    @(negedge clk); word_valid = v.v1; word_data = v.w1;
    #1 tk1 = word_ready && word_valid;
    @(negedge clk); word_valid = 1'b0;
    #1;
    chk(sample_valid == 1'b1, "R3 valid", {31'b0, sample_valid}, 32'd1);
    chk(ch0_sample == v.e0, {tag(i), " ch0"}, {12'b0, ch0_sample}, {12'b0, v.e0});
    chk(ch1_sample == v.e1, {tag(i), " ch1"}, {12'b0, ch1_sample}, {12'b0, v.e1});
    chk(tk0 == v.t0, {tag(i), " take0"}, {31'b0, tk0}, {31'b0, v.t0});
    chk(tk1 == v.t1, {tag(i), " take1"}, {31'b0, tk1}, {31'b0, v.t1});
    chk(underrun == v.u, {tag(i), " underrun"}, {31'b0, underrun}, {31'b0, v.u});
  endtask

  initial begin
    #100000;
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int pulses;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    // R1 reset state
    chk(ch0_sample == 0 && ch1_sample == 0, "R1 samples", {12'b0, ch0_sample}, 32'd0);
    chk(!underrun && !sample_valid && !word_ready, "R1 flags",
        {29'b0, underrun, sample_valid, word_ready}, 32'd0);

    for (int i = 0; i < NV; i++) apply(VEC[i], i);

    // R3: tick held into the service is ignored, one pulse only
    @(negedge clk); ctrl = 8'h00; tick = 1'b1;
    @(negedge clk);
    @(negedge clk); tick = 1'b0;
    pulses = 0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk); #1;
      if (sample_valid) pulses++;
    end
    chk(pulses == 1, "R3 tick during service", pulses, 32'd1);

    // R1 R7: underrun stays until reset, reset clears it
    chk(underrun == 1'b1, "R7 sticky before reset", {31'b0, underrun}, 32'd1);
    rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    #1 chk(underrun == 1'b0 && ch1_sample == 0, "R1 reset clears", {31'b0, underrun}, 32'd0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule